// File: doc/BRIEF.md
# Two-Key Register Write-Protect Gate

This block guards a peripheral's register bank against stray writes. It watches a simple write bus made of a single-cycle strobe, a byte address and a 32-bit data word. From these it produces a qualified write enable that the register bank uses in place of the raw strobe.

Writes that land in the protected address window are discarded while the gate is locked. To open the gate, software writes a fixed magic word to a first key register and then a second magic word to a second key register. Any other value written to either key register closes the gate again, and so does a first key written out of turn. Addresses outside the protected window, and the key registers themselves, are always passed through. A level output reports whether the gate is open.

The gate has no read path. Reads of the bank never pass through it, so they are never blocked.

Top module: `reg_write_lock`

## Requirements
- R1: After reset the gate is locked, so `unlocked` reads 0.
- R2: While locked, a write strobe to an address inside the protected window (byte addresses 0x00 up to 0x5C with the defaults) gives `wr_en_q` = 0 in that cycle.
- R3: A write to an address at or above the window limit (0x60 with the defaults) that is not a key register gives `wr_en_q` = 1, whatever the lock state.
- R4: Writing 0x83E70B13 to the first key register (address 0x6C) and then 0x95A4F1E0 to the second key register (address 0x70) sets `unlocked` to 1 from the cycle after the second write. From then on, protected writes give `wr_en_q` = 1.
- R5: The correct second key written without a correct first key immediately before it in the key sequence leaves the gate locked.
- R6: A value other than the expected key written to either key register, zero included, locks the gate and restarts the sequence.
- R7: Writes to the key registers always give `wr_en_q` = 1.
- R8: The correct first key written while the gate is open locks the gate but arms the sequence, so that a following correct second key reopens it.
- R9: Writes to non-key addresses, whether dropped or passed, leave the lock state and the key sequence unchanged.
- R10: `wr_en_q` is combinational in the same cycle as the strobe and is gated by the lock state held before that write. `unlocked` changes one cycle after a key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Raw write strobe, one cycle per write |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | KEY_W (32) | Write data |
| wr_en_q | output | 1 | Qualified write enable to the register bank |
| unlocked | output | 1 | 1 while protected writes are allowed |

## Verification
A wrong internal sequence state shows at the ports in one of two ways. `unlocked` takes the wrong value one cycle after a key write, or the next write to the protected window gets the wrong `wr_en_q` in that same cycle. The bench therefore follows every key-sequence pattern with a protected-window probe. This covers out-of-order keys, wrong and zero values, keys written to the wrong key register, re-keying while open, and unrelated writes between the two keys. Window-edge addresses are probed in both lock states to expose decode errors right away.

// File: rtl/wlock_pkg.sv
package wlock_pkg;
   localparam int KEY_W = 32;
   localparam logic [KEY_W-1:0] MAGIC_A = 32'h83E7_0B13;
   localparam logic [KEY_W-1:0] MAGIC_B = 32'h95A4_F1E0;

   function automatic int step_width(input int n_keys);
      return $clog2(n_keys + 1);
   endfunction
endpackage

// File: rtl/wlock_addr_decode.sv
module wlock_addr_decode #(
   parameter int ADDR_W = 8,
   parameter int NUM_KEYS = 2,
   parameter logic [ADDR_W-1:0] PROT_BASE = '0,
   parameter logic [ADDR_W-1:0] PROT_LIMIT = 8'h60,
   parameter logic [NUM_KEYS*ADDR_W-1:0] KEY_ADDRS = {8'h70, 8'h6C}
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_KEYS-1:0] key_hit,
   output logic                prot_hit
);
   for (genvar i = 0; i < NUM_KEYS; i++) begin : g_key
      assign key_hit[i] = (addr == KEY_ADDRS[i*ADDR_W +: ADDR_W]);
   end

   if (PROT_BASE == '0) begin : g_zero_base
      assign prot_hit = (addr < PROT_LIMIT);
   end else begin : g_offset_base
      assign prot_hit = (addr >= PROT_BASE) && (addr < PROT_LIMIT);
   end

   // R7: key addresses are distinct and never inside the window
   assert_key_decode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(key_hit) && !(prot_hit && (|key_hit)));
endmodule

// File: rtl/wlock_key_seq.sv
module wlock_key_seq
   import wlock_pkg::*;
#(
   parameter int NUM_KEYS = 2,
   parameter logic [NUM_KEYS*KEY_W-1:0] KEY_VALUES = {MAGIC_B, MAGIC_A}
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [NUM_KEYS-1:0] key_hit,
   input  logic [KEY_W-1:0]    wr_data,
   output logic                unlocked
);
   localparam int STEP_W = step_width(NUM_KEYS);
   localparam logic [STEP_W-1:0] OPEN_STEP = STEP_W'(NUM_KEYS);

   logic [STEP_W-1:0]   step_q, step_d;
   logic [NUM_KEYS-1:0] match;

   for (genvar i = 0; i < NUM_KEYS; i++) begin : g_match
      assign match[i] = (wr_data == KEY_VALUES[i*KEY_W +: KEY_W]);
   end

   always_comb begin
      step_d = step_q;
      for (int i = 0; i < NUM_KEYS; i++) begin
         if (wr_en && key_hit[i]) begin
            if (match[i] && i == 0)
               step_d = STEP_W'(1);
            else if (match[i] && step_q == STEP_W'(i))
               step_d = STEP_W'(i + 1);
            else
               step_d = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) step_q <= '0;
      else        step_q <= step_d;
   end

   assign unlocked = (step_q == OPEN_STEP);

   // R6: any mismatching key write closes the gate
   assert_bad_key_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && |(key_hit & ~match)) |=> !unlocked);
   // R4: the gate only opens right after a matching last key
   assert_open_after_last_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(wr_en && key_hit[NUM_KEYS-1] && match[NUM_KEYS-1]));
   // R9: non-key traffic leaves the sequence alone
   assert_other_writes_keep_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && |key_hit) |=> $stable(step_q));
endmodule

// File: rtl/reg_write_lock.sv
module reg_write_lock
   import wlock_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NUM_KEYS = 2,
   parameter logic [ADDR_W-1:0] PROT_BASE = '0,
   parameter logic [ADDR_W-1:0] PROT_LIMIT = 8'h60,
   parameter logic [NUM_KEYS*ADDR_W-1:0] KEY_ADDRS = {8'h70, 8'h6C},
   parameter logic [NUM_KEYS*KEY_W-1:0] KEY_VALUES = {MAGIC_B, MAGIC_A}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [KEY_W-1:0]  wr_data,
   output logic              wr_en_q,
   output logic              unlocked
);
   if (NUM_KEYS < 1) begin : g_bad_keys
      $error("reg_write_lock: NUM_KEYS must be at least 1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("reg_write_lock: ADDR_W too small");
   end
   if (PROT_LIMIT <= PROT_BASE) begin : g_bad_window
      $error("reg_write_lock: empty protected window");
   end

   logic [NUM_KEYS-1:0] key_hit;
   logic                prot_hit;

   wlock_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_KEYS(NUM_KEYS), .PROT_BASE(PROT_BASE),
      .PROT_LIMIT(PROT_LIMIT), .KEY_ADDRS(KEY_ADDRS)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .addr(wr_addr),
      .key_hit(key_hit), .prot_hit(prot_hit)
   );

   wlock_key_seq #(
      .NUM_KEYS(NUM_KEYS), .KEY_VALUES(KEY_VALUES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .key_hit(key_hit),
      .wr_data(wr_data), .unlocked(unlocked)
   );

   assign wr_en_q = wr_en && (!prot_hit || unlocked);

   // R1: reset leaves the gate locked
   assert_reset_locked_R1: assert property (@(posedge clk)
      !rst_n |=> !unlocked);
   // R2: protected writes are dropped while locked
   assert_drop_when_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && prot_hit && !unlocked) |-> !wr_en_q);
   // R3 / R7: writes outside the window always pass
   assert_pass_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !prot_hit) |-> wr_en_q);
   // R10: no enable without a strobe
   assert_no_spurious_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> !wr_en_q);
endmodule

// File: tb/tb_reg_write_lock.sv
module tb_reg_write_lock;
   localparam logic [31:0] KA = 32'h83E7_0B13;
   localparam logic [31:0] KB = 32'h95A4_F1E0;
   localparam logic [7:0]  AK0 = 8'h6C, AK1 = 8'h70;

   logic clk = 0, rst_n = 0, wr_en = 0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic wr_en_q, unlocked;

   int n_chk = 0, n_fail = 0;
   int model_step = 0;
   logic exp_we_q[$];
   logic exp_ul_q[$];
   string tag_q[$];
   bit done = 0;

   reg_write_lock dut (.*);

   always #10 clk = ~clk;

   task automatic check(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // Driver: computes expectations from the requirements, then drives.
   task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
      logic prot, ul;
      prot = (a < 8'h60);
      ul = (model_step == 2);
      exp_we_q.push_back(!prot || ul);      // R2 R3 R7 R10
      exp_ul_q.push_back(ul);
      tag_q.push_back(tag);
      if (a == AK0)
         model_step = (d == KA) ? 1 : 0;
      else if (a == AK1)
         model_step = (d == KB && model_step == 1) ? 2 : 0;
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   // Monitor: pops expectations while a strobe is present.
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (wr_en && exp_we_q.size() > 0) begin
            string t;
            t = tag_q.pop_front();
            check({t, " we"}, wr_en_q, exp_we_q.pop_front());
            check({t, " unlocked"}, unlocked, exp_ul_q.pop_front());
         end else if (!wr_en) begin
            check("R10 idle we", wr_en_q, 1'b0);
         end
      end
   end

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            check("R1 reset unlocked", unlocked, 1'b0);
            rst_n = 1;
            @(negedge clk);
            check("R1 after reset", unlocked, 1'b0);
            wr(8'h00, 32'h1, "R2 locked prot low");
            wr(8'h5C, 32'h2, "R2 locked prot edge");
            wr(8'h60, 32'h3, "R3 limit unprot");
            wr(8'hFC, 32'h4, "R3 top unprot");
            wr(AK0, KA, "R7 key0 pass");
            wr(AK1, KB, "R4 key1 pass");
            wr(8'h10, 32'h5, "R4 open prot");
            wr(8'h64, 32'h6, "R3 open unprot");
            wr(AK0, 32'h0, "R6 zero relock");
            wr(8'h10, 32'h7, "R6 probe");
            wr(AK1, KB, "R5 lone key1");
            wr(8'h10, 32'h8, "R5 probe");
            wr(AK0, KA, "R6 arm");
            wr(AK1, 32'hDEAD, "R6 bad key1");
            wr(AK1, KB, "R5 key1 after bad");
            wr(8'h20, 32'h9, "R6 probe2");
            wr(AK1, KA, "R6 swap key");
            wr(AK0, KB, "R6 swap key2");
            wr(8'h20, 32'hA, "R6 probe3");
            wr(AK0, KA, "R9 arm");
            wr(8'h30, 32'hB, "R9 dropped between");
            wr(8'h80, 32'hC, "R9 passed between");
            wr(AK1, KB, "R9 complete");
            wr(8'h30, 32'hD, "R9 open probe");
            wr(AK0, KA, "R8 rekey while open");
            wr(8'h30, 32'hE, "R8 locked probe");
            wr(AK1, KB, "R8 reopen");
            wr(8'h5C, 32'hF, "R8 open probe");
            wr(AK1, 32'h0, "R6 zero key1");
            wr(8'h5C, 32'h10, "R6 final probe");
            wr(AK0, KA, "R9 double arm");
            wr(AK0, KA, "R9 double arm2");
            wr(AK1, KB, "R4 reopen");
            wr(8'h00, 32'h11, "R4 final probe");
            repeat (3) @(negedge clk);
            done = 1;
         end
         begin
            repeat (5000) @(posedge clk);
            if (!done) begin
               n_chk++; n_fail++;
               $display("FAIL watchdog actual=timeout expected=finish");
            end
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule